// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

This engine moves outgoing frames from memory into a byte stream. Software builds frames in memory and describes each one in a two-word descriptor held in a small descriptor RAM. The even word holds status and length, and the odd word holds the buffer address. When transmission is enabled, the engine polls the descriptor at its current ring index. Once that descriptor is marked ready, the engine latches it and works out three things for the downstream framer: the frame length limits and whether a CRC is appended.

The engine then fetches the buffer one 32-bit word at a time over a request/valid read port and emits the bytes most significant first on a valid/ready stream. At the end of the frame it writes the cleaned status word back into the descriptor slot, with the ready bit cleared. It then reports success or failure, raises an interrupt request if either mask is set, and moves to the next ring slot.

Back-pressure rules: the memory request, once raised, stays up with a stable address until `mem_valid` is seen. On the byte stream, a byte is transferred in a cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_data` and `tx_last` hold their values. No new word is requested while bytes of the current word are still pending.

Top module: `tx_desc_dma`

## Requirements
- R1: After reset the engine is idle: no memory request, no byte valid, no writeback, ring index 0. It reads and consumes no descriptor while `tx_en` is low, even one marked ready.
- R2: With `tx_en` high and the ready bit (status bit 15) clear, the engine waits at the same index. If `tx_en` drops while it waits, it returns to idle and does not consume a descriptor made ready later until `tx_en` rises again.
- R3: The written-back status keeps the length (bits 31:16), wrap (14), pad (13), crc (12), last (11) and spare bits 10:9. It clears ready (15), the underrun flag (8), the retry count (7:4) and the four line flags (3:0).
- R4: `frame_min` is `min_frame` when the descriptor pad bit or `mode_pad` is set; otherwise it is the descriptor length.
- R5: `frame_max` is the descriptor length when `mode_huge` is set; otherwise it is `max_frame`.
- R6: `frame_crc` is set when `mode_crc` is set, or when both the descriptor crc bit and last bit are set.
- R7: The buffer is read at address base + count, with count starting at 0 and stepping by 4. The engine makes exactly ceil(length/4) reads, and `mem_req` with `mem_addr` holds steady until `mem_valid`.
- R8: Exactly length bytes leave the stream, in buffer order, each word most significant byte first. `tx_last` marks only the final byte. A zero-length frame sends no byte but is still written back.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` stay unchanged.
- R10: Completion takes one cycle. In that cycle `bd_wr_en` is high, and exactly one of `done_ok` / `done_err` is high. `done_err` is chosen when `tx_fail` was high on any accepted byte of the frame.
- R11: After a completion the ring index becomes 0 if the wrap bit was set or the index was the last pair (2*(NUM_BD-1)); otherwise it advances by 2.
- R12: `irq` pulses in the completion cycle when `mask_txb` or `mask_txe` is set, regardless of the outcome, and never outside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable |
| mode_pad | input | 1 | Global pad-to-minimum option |
| mode_huge | input | 1 | Allow frames longer than `max_frame` |
| mode_crc | input | 1 | Global CRC append |
| min_frame | input | 16 | Minimum frame length setting |
| max_frame | input | 16 | Maximum frame length setting |
| mask_txb | input | 1 | Success interrupt mask |
| mask_txe | input | 1 | Error interrupt mask |
| bd_idx | output | IDXW | Current ring word index (even) |
| bd_status | input | 32 | Descriptor RAM word at `bd_idx` |
| bd_bufaddr | input | AW | Descriptor RAM word at `bd_idx`+1 |
| bd_wr_en | output | 1 | Write `bd_wr_data` to word `bd_idx` |
| bd_wr_data | output | 32 | Status word written back |
| mem_req | output | 1 | Buffer read request |
| mem_addr | output | AW | Buffer read byte address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Byte valid |
| tx_data | output | 8 | Byte |
| tx_last | output | 1 | Final byte of frame |
| tx_ready | input | 1 | Byte accepted by downstream |
| tx_fail | input | 1 | Downstream failure, sampled on accepted bytes |
| frame_min | output | 16 | Minimum length for current frame |
| frame_max | output | 16 | Maximum length for current frame |
| frame_crc | output | 1 | Append CRC to current frame |
| done_ok | output | 1 | Completion without failure |
| done_err | output | 1 | Completion with failure |
| irq | output | 1 | Interrupt request pulse |

## Verification
A wrong ring index shows up at the next completion: the writeback lands on the wrong descriptor word, and `bd_idx` holds the wrong value in the cycle after `bd_wr_en`. A miscounted byte offset shows within one word fetch. It appears either as a wrong `mem_addr`, or as a byte count and `tx_last` position that disagree with the descriptor length by the end of the frame. A stale latched descriptor or failure flag shows in the completion cycle itself, through `bd_wr_data`, the frame limit outputs and the `done_ok`/`done_err` choice.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int LW = 16;
  localparam int SW = 32;
  localparam int ST_READY = 15;
  localparam int ST_WRAP  = 14;
  localparam int ST_PAD   = 13;
  localparam int ST_CRC   = 12;
  localparam int ST_LAST  = 11;
  localparam int LEN_LSB  = 16;
  // ready, underrun, retry count and line flags are cleared on accept
  localparam logic [SW-1:0] CLEAR_MASK = 32'h0000_81FF;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT_BD, S_FETCH, S_STREAM, S_FINISH
  } eng_state_e;
endpackage

// File: rtl/txd_desc_decode.sv
module txd_desc_decode
  import txd_pkg::*;
(
  input  logic [SW-1:0] status,
  input  logic          mode_pad,
  input  logic          mode_huge,
  input  logic          mode_crc,
  input  logic [LW-1:0] min_frame,
  input  logic [LW-1:0] max_frame,
  output logic          ready,
  output logic [LW-1:0] len,
  output logic [LW-1:0] min_len,
  output logic [LW-1:0] max_len,
  output logic          add_crc,
  output logic [SW-1:0] clean
);
  always_comb begin
    ready   = status[ST_READY];
    len     = status[LEN_LSB +: LW];
    min_len = (status[ST_PAD] || mode_pad) ? min_frame : len;
    max_len = mode_huge ? len : max_frame;
    add_crc = mode_crc || (status[ST_CRC] && status[ST_LAST]);
    clean   = status & ~CLEAR_MASK;
  end
endmodule

// File: rtl/txd_ring_index.sv
module txd_ring_index #(
  parameter int NUM_BD = 4,
  localparam int IDXW = $clog2(2 * NUM_BD)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  input  logic            wrap,
  output logic [IDXW-1:0] idx
);
  localparam logic [IDXW-1:0] LAST_PAIR = IDXW'(2 * (NUM_BD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (advance) begin
      if (wrap || idx >= LAST_PAIR) idx <= '0;
      else                          idx <= idx + IDXW'(2);
    end
  end
endmodule

// File: rtl/txd_byte_serializer.sv
module txd_byte_serializer #(
  parameter int WW = 32,
  localparam int NB = WW / 8,
  localparam int RW = $clog2(NB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [WW-1:0] word,
  input  logic [RW-1:0] nbytes,
  input  logic          frame_end,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_last,
  output logic          word_done
);
  logic [WW-1:0] sh;
  logic [RW-1:0] rem;
  logic          fe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh  <= '0;
      rem <= '0;
      fe  <= 1'b0;
    end else if (load) begin
      sh  <= word;
      rem <= nbytes;
      fe  <= frame_end;
    end else if (out_valid && out_ready) begin
      sh  <= {sh[WW-9:0], 8'h00};
      rem <= rem - RW'(1);
    end
  end

  assign out_valid = (rem != '0);
  assign out_data  = sh[WW-1 -: 8];
  assign out_last  = fe && (rem == RW'(1));
  assign word_done = out_valid && out_ready && (rem == RW'(1));
endmodule

// File: rtl/tx_desc_dma.sv
module tx_desc_dma
  import txd_pkg::*;
#(
  parameter int AW = 32,
  parameter int NUM_BD = 4,
  localparam int IDXW = $clog2(2 * NUM_BD)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_en,
  input  logic            mode_pad,
  input  logic            mode_huge,
  input  logic            mode_crc,
  input  logic [15:0]     min_frame,
  input  logic [15:0]     max_frame,
  input  logic            mask_txb,
  input  logic            mask_txe,
  output logic [IDXW-1:0] bd_idx,
  input  logic [31:0]     bd_status,
  input  logic [AW-1:0]   bd_bufaddr,
  output logic            bd_wr_en,
  output logic [31:0]     bd_wr_data,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  input  logic            mem_valid,
  input  logic [31:0]     mem_rdata,
  output logic            tx_valid,
  output logic [7:0]      tx_data,
  output logic            tx_last,
  input  logic            tx_ready,
  input  logic            tx_fail,
  output logic [15:0]     frame_min,
  output logic [15:0]     frame_max,
  output logic            frame_crc,
  output logic            done_ok,
  output logic            done_err,
  output logic            irq
);
  localparam int CW = LW + 1;
  localparam int WB = 4;
  localparam int RW = $clog2(WB + 1);

  eng_state_e    state;
  logic [CW-1:0] count;
  logic [LW-1:0] len_q;
  logic [AW-1:0] base_q;
  logic [SW-1:0] stat_q;
  logic          fail_q;

  logic          dec_ready, dec_crc;
  logic [LW-1:0] dec_len, dec_min, dec_max;
  logic [SW-1:0] dec_clean;

  logic [CW-1:0] len_ext, remaining;
  logic [RW-1:0] nbytes;
  logic          frame_end, ser_load, word_done, finishing;

  txd_desc_decode u_dec (
    .status    (bd_status),
    .mode_pad  (mode_pad),
    .mode_huge (mode_huge),
    .mode_crc  (mode_crc),
    .min_frame (min_frame),
    .max_frame (max_frame),
    .ready     (dec_ready),
    .len       (dec_len),
    .min_len   (dec_min),
    .max_len   (dec_max),
    .add_crc   (dec_crc),
    .clean     (dec_clean)
  );

  assign finishing = (state == S_FINISH);

  txd_ring_index #(.NUM_BD(NUM_BD)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (finishing),
    .wrap    (stat_q[ST_WRAP]),
    .idx     (bd_idx)
  );

  always_comb begin
    len_ext   = {1'b0, len_q};
    remaining = len_ext - count;
    nbytes    = (remaining >= CW'(WB)) ? RW'(WB) : RW'(remaining);
    frame_end = (count + CW'(WB)) >= len_ext;
    ser_load  = (state == S_FETCH) && mem_valid;
  end

  txd_byte_serializer #(.WW(32)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ser_load),
    .word      (mem_rdata),
    .nbytes    (nbytes),
    .frame_end (frame_end),
    .out_ready (tx_ready),
    .out_valid (tx_valid),
    .out_data  (tx_data),
    .out_last  (tx_last),
    .word_done (word_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      count     <= '0;
      len_q     <= '0;
      base_q    <= '0;
      stat_q    <= '0;
      fail_q    <= 1'b0;
      frame_min <= '0;
      frame_max <= '0;
      frame_crc <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (tx_en) state <= S_WAIT_BD;
        S_WAIT_BD: begin
          if (dec_ready) begin
            stat_q    <= dec_clean;
            len_q     <= dec_len;
            base_q    <= bd_bufaddr;
            count     <= '0;
            fail_q    <= 1'b0;
            frame_min <= dec_min;
            frame_max <= dec_max;
            frame_crc <= dec_crc;
            state     <= (dec_len == '0) ? S_FINISH : S_FETCH;
          end else if (!tx_en) begin
            state <= S_IDLE;
          end
        end
        S_FETCH: begin
          if (mem_valid) begin
            count <= count + CW'(WB);
            state <= S_STREAM;
          end
        end
        S_STREAM: begin
          if (tx_valid && tx_ready && tx_fail) fail_q <= 1'b1;
          if (word_done) state <= (count >= len_ext) ? S_FINISH : S_FETCH;
        end
        S_FINISH: state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  assign mem_req    = (state == S_FETCH);
  assign mem_addr   = base_q + AW'(count);
  assign bd_wr_en   = finishing;
  assign bd_wr_data = stat_q;
  assign done_ok    = finishing && !fail_q;
  assign done_err   = finishing && fail_q;
  assign irq        = finishing && (mask_txb || mask_txe);
endmodule

// File: rtl/tx_desc_dma_chk.sv
module tx_desc_dma_chk #(
  parameter int AW = 32,
  parameter int IDXW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [IDXW-1:0] bd_idx,
  input logic            bd_wr_en,
  input logic [31:0]     bd_wr_data,
  input logic            mem_req,
  input logic [AW-1:0]   mem_addr,
  input logic            mem_valid,
  input logic            tx_valid,
  input logic [7:0]      tx_data,
  input logic            tx_last,
  input logic            tx_ready,
  input logic            done_ok,
  input logic            done_err,
  input logic            irq
);
  // R9
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req && $stable(mem_addr));

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && tx_valid));

  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bd_wr_en |-> $countones({done_ok, done_err}) == 1);

  // R10
  outcome_only_at_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok || done_err) |-> bd_wr_en);

  // R12
  irq_at_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> bd_wr_en);

  // R3
  ready_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bd_wr_en |-> !bd_wr_data[15]);

  // R11
  ring_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bd_wr_en |=> (bd_idx == '0) || (bd_idx == $past(bd_idx) + IDXW'(2)));

  // R11
  ring_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bd_wr_en |=> $stable(bd_idx));
endmodule

bind tx_desc_dma tx_desc_dma_chk #(.AW(AW), .IDXW(IDXW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bd_idx     (bd_idx),
  .bd_wr_en   (bd_wr_en),
  .bd_wr_data (bd_wr_data),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_valid  (mem_valid),
  .tx_valid   (tx_valid),
  .tx_data    (tx_data),
  .tx_last    (tx_last),
  .tx_ready   (tx_ready),
  .done_ok    (done_ok),
  .done_err   (done_err),
  .irq        (irq)
);

// File: tb/tb_tx_desc_dma.sv
`timescale 1ns/1ps
module tb_tx_desc_dma;
  localparam int AW = 32;
  localparam int NUM_BD = 4;
  localparam int IDXW = $clog2(2 * NUM_BD);
  localparam int NW = 2 * NUM_BD;

  typedef struct packed {
    logic [15:0] len;
    logic dpad, dcrc, dlast, mpad, mhuge, mcrc;
    logic [15:0] emin, emax;
    logic ecrc;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{16'd8, 1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 16'd8,  16'd1536, 1'b0},
    '{16'd5, 1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0, 16'd60, 16'd1536, 1'b0},
    '{16'd7, 1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0, 16'd7,  16'd1536, 1'b1},
    '{16'd6, 1'b0,1'b1,1'b0, 1'b0,1'b1,1'b0, 16'd6,  16'd6,    1'b0},
    '{16'd9, 1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1, 16'd60, 16'd1536, 1'b1},
    '{16'd4, 1'b0,1'b0,1'b1, 1'b0,1'b1,1'b0, 16'd4,  16'd4,    1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 0, mode_pad = 0, mode_huge = 0, mode_crc = 0;
  logic [15:0] min_frame = 16'd60, max_frame = 16'd1536;
  logic mask_txb = 1, mask_txe = 0;
  logic [IDXW-1:0] bd_idx;
  logic [31:0] bd_status;
  logic [AW-1:0] bd_bufaddr;
  logic bd_wr_en;
  logic [31:0] bd_wr_data;
  logic mem_req, mem_valid = 0;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic tx_valid, tx_last, tx_ready = 1, tx_fail = 0;
  logic [7:0] tx_data;
  logic [15:0] frame_min, frame_max;
  logic frame_crc, done_ok, done_err, irq;

  int tests = 0, fails = 0;
  logic [31:0] dram [NW];
  logic [7:0] cap_data [4096];
  logic cap_last [4096];
  int ncap = 0, nfetch = 0, nwb = 0, nreq = 0;
  logic bp_on = 0;
  logic [7:0] lfsr = 8'hA5;
  int exp_idx = 0;

  always #2 clk = ~clk;

  tx_desc_dma #(.AW(AW), .NUM_BD(NUM_BD)) dut (.*);

  assign bd_status  = dram[int'(bd_idx)];
  assign bd_bufaddr = dram[int'(bd_idx) + 1];

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) ^ (a >> 8));
  endfunction

  always @(posedge clk) begin
    mem_valid <= mem_req && !mem_valid;
    mem_rdata <= {pat(int'(mem_addr)), pat(int'(mem_addr) + 1),
                  pat(int'(mem_addr) + 2), pat(int'(mem_addr) + 3)};
    if (mem_req) nreq <= nreq + 1;
    if (mem_valid && mem_req) nfetch <= nfetch + 1;
    if (bd_wr_en) begin
      dram[int'(bd_idx)] <= bd_wr_data;
      nwb <= nwb + 1;
    end
    if (tx_valid && tx_ready) begin
      cap_data[ncap] <= tx_data;
      cap_last[ncap] <= tx_last;
      ncap <= ncap + 1;
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_ready <= bp_on ? lfsr[0] : 1'b1;
  end

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_status(int len, logic wrap, logic pad, logic crc, logic last);
    return (32'(len) << 16) | 32'h0000_8000 | (32'(wrap) << 14) | (32'(pad) << 13) |
           (32'(crc) << 12) | (32'(last) << 11) | 32'h0000_0600 | 32'h0000_01FF;
  endfunction

  function automatic logic [31:0] exp_wb(int len, logic wrap, logic pad, logic crc, logic last);
    return (32'(len) << 16) | (32'(wrap) << 14) | (32'(pad) << 13) |
           (32'(crc) << 12) | (32'(last) << 11) | 32'h0000_0600;
  endfunction

  // result of the last completion
  logic [31:0] r_wb;
  logic r_ok, r_err, r_irq, r_crc;
  logic [15:0] r_min, r_max;
  int r_idx_at, r_idx_after;

  task automatic post(input int base, input logic [31:0] st);
    @(negedge clk);
    dram[exp_idx + 1] = 32'(base);
    dram[exp_idx] = st;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    @(negedge clk);
    while (!bd_wr_en && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(bd_wr_en, {tag, " completion"}, n, 0);
    r_wb = bd_wr_data; r_ok = done_ok; r_err = done_err; r_irq = irq;
    r_min = frame_min; r_max = frame_max; r_crc = frame_crc; r_idx_at = int'(bd_idx);
    @(negedge clk);
    r_idx_after = int'(bd_idx);
  endtask

  task automatic check_bytes(input int c0, input int base, input int len, input string tag);
    chk(ncap - c0 == len, {tag, " byte count"}, ncap - c0, len);
    for (int j = 0; j < len; j++) begin
      chk(cap_data[c0 + j] == pat(base + j), {tag, " byte value"}, cap_data[c0 + j], pat(base + j));
      chk(cap_last[c0 + j] == (j == len - 1), {tag, " last flag"}, cap_last[c0 + j], j == len - 1);
    end
  endtask

  function automatic int next_idx(int idx, logic wrap);
    return (wrap || idx >= 2 * (NUM_BD - 1)) ? 0 : idx + 2;
  endfunction

  initial begin
    automatic int c0, f0, w0, r0, base, len;
    for (int i = 0; i < NW; i++) dram[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!mem_req && !tx_valid && !bd_wr_en && !irq, "R1 idle outputs", {mem_req, tx_valid, bd_wr_en, irq}, 0);
    chk(bd_idx == 0, "R1 reset index", bd_idx, 0);

    // R1 disabled engine ignores a ready descriptor
    post(32'h80, mk_status(4, 0, 0, 0, 0));
    w0 = nwb; r0 = nreq;
    repeat (20) @(negedge clk);
    chk(nwb == w0 && nreq == r0, "R1 no consume while disabled", nwb - w0, 0);
    dram[0] = '0;

    // vector table
    tx_en = 1;
    for (int k = 0; k < NV; k++) begin
      vec_t v = VECS[k];
      mode_pad = v.mpad; mode_huge = v.mhuge; mode_crc = v.mcrc;
      base = 'h100 * (k + 1); len = int'(v.len);
      c0 = ncap; f0 = nfetch;
      post(base, mk_status(len, 0, v.dpad, v.dcrc, v.dlast));
      wait_done("vec");
      chk(r_idx_at == exp_idx, "R11 writeback slot", r_idx_at, exp_idx);
      chk(r_wb == exp_wb(len, 0, v.dpad, v.dcrc, v.dlast), "R3 writeback", r_wb, exp_wb(len, 0, v.dpad, v.dcrc, v.dlast));
      chk(r_min == v.emin, "R4 min length", r_min, v.emin);
      chk(r_max == v.emax, "R5 max length", r_max, v.emax);
      chk(r_crc == v.ecrc, "R6 crc decision", r_crc, v.ecrc);
      chk(nfetch - f0 == (len + 3) / 4, "R7 fetch count", nfetch - f0, (len + 3) / 4);
      check_bytes(c0, base, len, "R8");
      chk(r_ok && !r_err, "R10 success", {r_ok, r_err}, 2'b10);
      chk(r_irq, "R12 irq with txb mask", r_irq, 1);
      exp_idx = next_idx(exp_idx, 0);
      chk(r_idx_after == exp_idx, "R11 ring advance", r_idx_after, exp_idx);
    end
    mode_pad = 0; mode_huge = 0; mode_crc = 0;

    // R9 back-pressure
    bp_on = 1; c0 = ncap; base = 'h900;
    post(base, mk_status(11, 0, 0, 0, 1));
    wait_done("R9");
    check_bytes(c0, base, 11, "R9");
    exp_idx = next_idx(exp_idx, 0);
    bp_on = 0;

    // R10 failure path
    tx_fail = 1;
    post('h a00, mk_status(6, 0, 0, 0, 0));
    wait_done("R10");
    tx_fail = 0;
    chk(r_err && !r_ok, "R10 failure outcome", {r_ok, r_err}, 2'b01);
    chk(r_wb == exp_wb(6, 0, 0, 0, 0), "R10 failure writeback", r_wb, exp_wb(6, 0, 0, 0, 0));
    exp_idx = next_idx(exp_idx, 0);

    // R12 masks
    mask_txb = 0; mask_txe = 0;
    post('hb00, mk_status(3, 0, 0, 0, 0));
    wait_done("R12");
    chk(!r_irq, "R12 no irq when masked", r_irq, 0);
    exp_idx = next_idx(exp_idx, 0);
    mask_txe = 1;
    post('hb40, mk_status(3, 0, 0, 0, 0));
    wait_done("R12");
    chk(r_irq && r_ok, "R12 irq via txe mask on success", r_irq, 1);
    exp_idx = next_idx(exp_idx, 0);
    mask_txb = 1; mask_txe = 0;

    // R11 wrap bit at a nonzero slot
    if (exp_idx == 0) begin
      post('hc00, mk_status(2, 0, 0, 0, 0));
      wait_done("R11");
      exp_idx = next_idx(exp_idx, 0);
    end
    post('hc40, mk_status(2, 1, 0, 0, 0));
    wait_done("R11");
    chk(r_idx_after == 0, "R11 wrap to zero", r_idx_after, 0);
    exp_idx = 0;

    // R8 zero length
    c0 = ncap; f0 = nfetch;
    post('hd00, mk_status(0, 0, 0, 0, 0));
    wait_done("R8");
    chk(ncap == c0 && nfetch == f0, "R8 zero length sends nothing", ncap - c0, 0);
    chk(r_wb == exp_wb(0, 0, 0, 0, 0), "R8 zero length writeback", r_wb, 0);
    exp_idx = next_idx(exp_idx, 0);

    // R2 waiting and dropping enable
    w0 = nwb; r0 = nreq;
    repeat (10) @(negedge clk);
    chk(nwb == w0 && bd_idx == IDXW'(exp_idx), "R2 waits on not-ready", nwb - w0, 0);
    tx_en = 0;
    repeat (5) @(negedge clk);
    post('he00, mk_status(5, 0, 0, 0, 0));
    repeat (20) @(negedge clk);
    chk(nwb == w0 && nreq == r0, "R2 idle after enable drop", nreq - r0, 0);
    c0 = ncap;
    tx_en = 1;
    wait_done("R2");
    check_bytes(c0, 'he00, 5, "R2");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    fails++;
    tests++;
    $display("FAIL watchdog: run did not complete actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule